// File: doc/BRIEF.md
# Sequential 8x8 Multiply Unit for an Accumulator CPU

This unit executes the accumulator CPU's one-byte register multiply instruction. The instruction uses inherent addressing and has opcode 0x42. The unit multiplies the index register by the accumulator as unsigned numbers. It then hands back the 16-bit product as two register values: the upper byte goes to the index register and the lower byte goes to the accumulator. The core's decoder raises `start` for one cycle, in the fetch cycle of the instruction, and presents the current X and A on `xIn` and `aIn` in that same cycle.

Inside, a shift-and-add engine forms one partial product per clock. The engine then idles until the instruction's fixed total of 11 cycles has elapsed. In the eleventh cycle `done` pulses. In that cycle the new register values appear on `xOut`/`aOut` and stay there until the next completion. Also in that cycle, the half-carry and carry write strobes fire with the value zero. The interrupt mask, negative and zero flags get no strobe, so the core's condition-code register keeps them unchanged.

Top module: `xa_mult_unit`

## Requirements
- R1: The 16-bit value {xOut, aOut} in the done cycle equals the unsigned product of the xIn and aIn values sampled with the accepted start.
- R2: The upper byte (bits 15..8) of the product is on xOut and the lower byte (bits 7..0) is on aOut.
- R3: Take the cycle in which an accepted start is high as cycle 1. Then done is high in cycle 11 only, for exactly one cycle.
- R4: In the done cycle, hWrEn and cWrEn are both 1 and hWrVal and cWrVal are both 0, which clears half-carry and carry.
- R5: Outside the done cycle, hWrEn and cWrEn are 0. No other flag is ever written.
- R6: A start that arrives while an operation is in flight is ignored, and so is a start in the done cycle. Changes on xIn/aIn after the accepted start have no effect on the result.
- R7: xOut and aOut keep their previous values until the done cycle of the next operation.
- R8: Reset is synchronous and active-high. It returns the unit to idle with done and both strobes at 0 and xOut = aOut = 0, and it abandons any operation in flight.
- R9: A start in the cycle right after a done cycle is accepted, so back-to-back instructions are 11 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiply (fetch cycle of the instruction) |
| xIn | input | 8 | Index register operand |
| aIn | input | 8 | Accumulator operand |
| xOut | output | 8 | New index register value (product upper byte) |
| aOut | output | 8 | New accumulator value (product lower byte) |
| done | output | 1 | One-cycle completion pulse |
| hWrEn | output | 1 | Half-carry flag write strobe |
| hWrVal | output | 1 | Half-carry value to write (always 0) |
| cWrEn | output | 1 | Carry flag write strobe |
| cWrVal | output | 1 | Carry value to write (always 0) |

## Verification
Two events can coincide: completion of one multiply and a fresh start request. A start can arrive in the done cycle itself, where it must be dropped. It can also arrive in the very next cycle, where it must be taken. The bench raises a start with different operands in the done cycle of some operations and then watches an idle window, where any extra done pulse or output change is an error. Other runs begin the next multiply exactly one cycle after done, and each of those must finish with the correct product 11 cycles later.

// File: rtl/xa_mult_pkg.sv
package xa_mult_pkg;

  typedef struct packed {
    logic load;    // capture operands, clear accumulator
    logic step;    // one shift-and-add partial product
    logic commit;  // move product to output registers
  } mulStrobes_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } mulPhase_e;

endpackage

// File: rtl/xa_mult_ctrl.sv
module xa_mult_ctrl
  import xa_mult_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int LATENCY = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output mulStrobes_t strobes,
  output logic        done
);

  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [CNT_W-1:0] STEP_LAST = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] COMMIT_AT = CNT_W'(LATENCY - 2);

  mulPhase_e        phase;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    strobes.load   = (phase == PH_IDLE) && start;
    strobes.step   = (phase == PH_RUN) && (cnt != '0) && (cnt <= STEP_LAST);
    strobes.commit = (phase == PH_RUN) && (cnt == COMMIT_AT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_RUN;
            cnt   <= CNT_W'(1);
          end
        end
        PH_RUN: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == COMMIT_AT) phase <= PH_DONE;
        end
        PH_DONE: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
        default: begin
          phase <= PH_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

  assign done = (phase == PH_DONE);

  // R3: completion is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: a start while running does not restart the count
  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_RUN && start && cnt != COMMIT_AT) |=> (phase == PH_RUN && cnt == $past(cnt) + CNT_W'(1)));

  // R6: a start in the done cycle is dropped
  assert_done_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (done && start) |=> (phase == PH_IDLE));

endmodule

// File: rtl/xa_mult_dp.sv
module xa_mult_dp
  import xa_mult_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  mulStrobes_t      strobes,
  input  logic [WIDTH-1:0] xIn,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] xOut,
  output logic [WIDTH-1:0] aOut
);

  localparam int PW = 2 * WIDTH;
  localparam int SW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] mcand;
  logic [WIDTH-1:0] hiQ;
  logic [WIDTH-1:0] loQ;
  logic [WIDTH-1:0] xOutQ;
  logic [WIDTH-1:0] aOutQ;
  logic [WIDTH:0]   addend;
  logic [WIDTH:0]   sum;

  always_comb begin
    addend = loQ[0] ? {1'b0, mcand} : '0;
    sum    = {1'b0, hiQ} + addend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand <= '0;
      hiQ   <= '0;
      loQ   <= '0;
    end else if (strobes.load) begin
      mcand <= xIn;
      hiQ   <= '0;
      loQ   <= aIn;
    end else if (strobes.step) begin
      hiQ <= sum[WIDTH:1];
      loQ <= {sum[0], loQ[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xOutQ <= '0;
      aOutQ <= '0;
    end else if (strobes.commit) begin
      xOutQ <= hiQ;
      aOutQ <= loQ;
    end
  end

  assign xOut = xOutQ;
  assign aOut = aOutQ;

  // Assertion support: original multiplier and a count of steps taken
  logic [WIDTH-1:0] opAHold;
  logic [SW-1:0]    stepsSeen;
  logic [PW-1:0]    expProd;

  always_ff @(posedge clk) begin
    if (rst) begin
      opAHold   <= '0;
      stepsSeen <= '0;
    end else if (strobes.load) begin
      opAHold   <= aIn;
      stepsSeen <= '0;
    end else if (strobes.step) begin
      stepsSeen <= stepsSeen + SW'(1);
    end
  end

  assign expProd = PW'(mcand) * PW'(opAHold);

  // R1: accumulator holds the full product when committed
  assert_product_R1: assert property (@(posedge clk) disable iff (rst)
    strobes.commit |-> ({hiQ, loQ} == expProd));

  // R1: exactly WIDTH partial products before commit
  assert_step_count_R1: assert property (@(posedge clk) disable iff (rst)
    strobes.commit |-> (stepsSeen == SW'(WIDTH)));

  // R2: upper byte lands on xOut, lower on aOut
  assert_split_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.commit |=> ({xOut, aOut} == $past(expProd)));

  // R7: outputs hold between completions
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !strobes.commit |=> ($stable(xOut) && $stable(aOut)));

  // R6: operands only change on an accepted start
  assert_operands_R6: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> ($stable(mcand) && $stable(opAHold)));

endmodule

// File: rtl/xa_mult_unit.sv
module xa_mult_unit
  import xa_mult_pkg::*;
#(
  parameter int WIDTH   = 8,
  parameter int LATENCY = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] xIn,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] xOut,
  output logic [WIDTH-1:0] aOut,
  output logic             done,
  output logic             hWrEn,
  output logic             hWrVal,
  output logic             cWrEn,
  output logic             cWrVal
);

  localparam int LW = $clog2(LATENCY + 1);

  mulStrobes_t strobes;

  xa_mult_ctrl #(.WIDTH(WIDTH), .LATENCY(LATENCY)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  xa_mult_dp #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .xIn     (xIn),
    .aIn     (aIn),
    .xOut    (xOut),
    .aOut    (aOut)
  );

  assign hWrEn  = done;
  assign cWrEn  = done;
  assign hWrVal = 1'b0;
  assign cWrVal = 1'b0;

  // Assertion support: cycles since the accepted start
  logic [LW-1:0] latCnt;
  always_ff @(posedge clk) begin
    if (rst || done)       latCnt <= '0;
    else if (strobes.load) latCnt <= LW'(1);
    else if (latCnt != '0) latCnt <= latCnt + LW'(1);
  end

  // R3: done rises in the last cycle of the fixed instruction length
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> (latCnt == LW'(LATENCY - 1)));

endmodule

// File: tb/xa_mult_unit_tb_top.sv
module xa_mult_unit_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] xIn = '0;
  logic [7:0] aIn = '0;
  logic [7:0] xOut, aOut;
  logic       done, hWrEn, hWrVal, cWrEn, cWrVal;

  int  nTests = 0;
  int  nFail  = 0;
  bit  finished = 0;
  logic [7:0] prevX = '0;
  logic [7:0] prevA = '0;

  always #2.5 clk = ~clk;

  xa_mult_unit dut_i (
    .clk(clk), .rst(rst), .start(start), .xIn(xIn), .aIn(aIn),
    .xOut(xOut), .aOut(aOut), .done(done),
    .hWrEn(hWrEn), .hWrVal(hWrVal), .cWrEn(cWrEn), .cWrVal(cWrVal)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // Drives start at the current negedge; returns at the negedge after done.
  task automatic runOp(input logic [7:0] x, input logic [7:0] a,
                       input bit glitch, input bit b2b);
    logic [15:0] expP;
    bit earlyDone, holdBad, flagBad;
    expP = 16'(x) * 16'(a);
    earlyDone = 0; holdBad = 0; flagBad = 0;
    start = 1'b1; xIn = x; aIn = a;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k < 10) begin
        if (done) earlyDone = 1;
        if (xOut != prevX || aOut != prevA) holdBad = 1;
        if (hWrEn || cWrEn) flagBad = 1;
        start = glitch && (k == 3);
        xIn = x ^ 8'(k * 37);
        aIn = a + 8'(k);
      end
    end
    check(!earlyDone, "R3", "done before cycle 11", 32'(earlyDone), 0);
    check(!holdBad, "R7", "outputs moved early", {16'h0, xOut, aOut}, {16'h0, prevX, prevA});
    check(!flagBad, "R5", "flag strobe outside done", 32'(flagBad), 0);
    check(done == 1'b1, b2b ? "R9" : "R3", "done in cycle 11", 32'(done), 1);
    check({xOut, aOut} == expP, "R1", "product", {16'h0, xOut, aOut}, {16'h0, expP});
    check(xOut == expP[15:8] && aOut == expP[7:0], "R2", "byte split",
          {16'h0, xOut, aOut}, {16'h0, expP});
    check(hWrEn && cWrEn && !hWrVal && !cWrVal, "R4", "flag clear strobes",
          {28'h0, hWrEn, hWrVal, cWrEn, cWrVal}, 32'hA);
    start = glitch;          // start in the done cycle must be dropped (R6)
    xIn = ~x; aIn = ~a;
    @(negedge clk);
    check(done == 1'b0, "R3", "done is one cycle", 32'(done), 0);
    start = 1'b0;
    prevX = expP[15:8];
    prevA = expP[7:0];
  endtask

  task automatic idleWatch(input int n, input string req);
    bit bad = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (done || xOut != prevX || aOut != prevA || hWrEn || cWrEn) bad = 1;
    end
    check(!bad, req, "no activity after ignored start", 32'(bad), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsrX, lfsrA;
    logic [7:0] aSet [10];
    aSet = '{8'h00, 8'h01, 8'h02, 8'h0F, 8'h55, 8'h7F, 8'h80, 8'hAA, 8'hF0, 8'hFF};
    repeat (3) @(negedge clk);
    // R8: reset state
    check(done == 1'b0, "R8", "done after reset", 32'(done), 0);
    check(!hWrEn && !cWrEn, "R8", "strobes after reset", {30'h0, hWrEn, cWrEn}, 0);
    check(xOut == 8'h00, "R8", "xOut after reset", 32'(xOut), 0);
    check(aOut == 8'h00, "R8", "aOut after reset", 32'(aOut), 0);
    rst = 1'b0;
    @(negedge clk);

    // Sweep all X against corner A values, back-to-back (R9)
    for (int i = 0; i < 10; i++)
      for (int x = 0; x < 256; x++)
        runOp(8'(x), aSet[i], 1'b0, 1'b1);

    // Sweep all A against extreme X values
    for (int a = 0; a < 256; a++) runOp(8'hFF, 8'(a), 1'b0, 1'b1);
    for (int a = 0; a < 256; a++) runOp(8'h00, 8'(a), 1'b0, 1'b1);

    // Pseudo-random pairs
    lfsrX = 8'hB5; lfsrA = 8'h3C;
    for (int n = 0; n < 1000; n++) begin
      lfsrX = {lfsrX[6:0], lfsrX[7] ^ lfsrX[5] ^ lfsrX[4] ^ lfsrX[3]};
      lfsrA = {lfsrA[6:0], lfsrA[7] ^ lfsrA[5] ^ lfsrA[4] ^ lfsrA[3]};
      runOp(lfsrX, lfsrA, 1'b0, 1'b1);
    end

    // R6: starts while busy and in the done cycle are ignored
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      runOp(8'(n * 29 + 3), 8'(255 - n * 17), 1'b1, 1'b0);
      idleWatch(14, "R6");
    end

    // R8: reset mid-operation abandons it and clears outputs
    @(negedge clk);
    start = 1'b1; xIn = 8'hC3; aIn = 8'h9E;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    prevX = '0; prevA = '0;
    idleWatch(14, "R8");

    // Normal operation resumes after the abort
    runOp(8'hFF, 8'hFF, 1'b0, 1'b0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule